// File: doc/BRIEF.md
# Bridge Address Source Selector

This block sits between a processor core's bus interface and an AHB master port and decides, every cycle, where the outgoing AHB address comes from. There are three sources. The live core address is used when the core access and the AHB address phase happen in the same cycle. A registered copy of the last address placed on the bus is used while the AHB stalls the transfer, so the core may move on. A locally incremented address is used for noncacheable read bursts: a look-ahead hint from the core says another read follows, so the next address phase starts one cycle before the core presents it.

A small state machine tracks whether a predicted address is outstanding. In `ST_IDLE`, the core address goes straight out. A read with the burst-continue hint moves to `ST_LEAD`. In `ST_LEAD` the incremented address is issued without looking at the core, and the machine moves to `ST_CHECK`. A merged idle-then-sequential hint also moves from `ST_IDLE` to `ST_CHECK` and issues the core address one cycle early. In `ST_CHECK` the core must present the address that was issued ahead. On a match with the hint, the machine stays in `ST_CHECK` and issues the next increment. On a match without the hint, it returns to `ST_IDLE` with no address. On a mismatch, or when no core access is present, the prediction is dropped. While `hready` is low the state freezes and all bus outputs hold.

The block also forms the 4-bit protection code from the access attributes. Incremented beats reuse the code of the beat before them.

Top module: `bridge_addr_sel`

## Requirements
- R1: In `ST_IDLE` with `hready`=1 and `core_valid`=1, the block drives `haddr`=`core_addr`, `addr_valid`=1, `addr_src`=1 (core), `addr_seq`=0 and `pred_drop`=0 in that same cycle. With no access and no merge hint it drives `addr_valid`=0 and `addr_src`=0.
- R2: In `ST_IDLE` with `hready`=1, `core_valid`=0 and `merge_next`=1, the block issues `core_addr` early (`addr_src`=1, `addr_valid`=1) and expects that address from the core in the next accepted cycle.
- R3: After an accepted read (`core_write`=0) that carries `burst_more`=1, the next cycle with `hready`=1 issues the previous bus address plus the beat size, with `addr_src`=3 and `addr_seq`=1. All core inputs are ignored in that cycle.
- R4: The beat size in bytes comes from the size code: 0 gives 1, 1 gives 2, 2 and 3 give 4. The sum wraps modulo 2^ADDR_W.
- R5: In `ST_CHECK`, when the core presents a read whose address equals the address issued last: with `burst_more`=1 the next incremented address is issued (`addr_src`=3). With `burst_more`=0 no address is issued (`addr_valid`=0, `addr_src`=0) and `haddr` keeps the last bus address.
- R6: In `ST_CHECK`, a core access with another address, or any write, drops the prediction (`pred_drop`=1). The core address is then issued as a fresh transfer with `addr_seq`=0. If no core access is present, `pred_drop`=1 and `addr_valid`=0.
- R7: While `hready`=0, `addr_src`=2 and `haddr`, `hprot`, `addr_valid` and `addr_seq` equal their values in the most recent cycle with `hready`=1 (zero if none since reset). The state does not change.
- R8: For core-sourced addresses, `hprot` = {`core_ptw` OR (read AND `core_cacheable`), write AND `core_bufferable`, `core_priv`, `core_data`}. Bit 3 is therefore forced to 1 on page-table walks and is 0 on writes that are not walks. Bit 2 is 0 on reads.
- R9: Incremented addresses carry the `hprot` value of the bus address they follow.
- R10: After reset, with `hready`=1 and no core access, `addr_valid`=0, `addr_src`=0, `addr_seq`=0, `pred_drop`=0 and `haddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core presents an access this cycle |
| core_write | input | 1 | Access is a write |
| core_addr | input | ADDR_W | Core address |
| core_size | input | 2 | Size code: 0 byte, 1 halfword, 2 or 3 word |
| core_cacheable | input | 1 | Region is cacheable |
| core_bufferable | input | 1 | Region is bufferable |
| core_priv | input | 1 | Privileged access |
| core_data | input | 1 | Data access (0 = opcode fetch) |
| core_ptw | input | 1 | Page-table walk access |
| burst_more | input | 1 | Another noncacheable read follows this one |
| merge_next | input | 1 | Idle cycle carries control for the next sequential access |
| hready | input | 1 | AHB accepts the address phase this cycle |
| haddr | output | ADDR_W | AHB address |
| hprot | output | 4 | AHB protection code |
| addr_valid | output | 1 | An address phase is presented |
| addr_seq | output | 1 | Address is a sequential continuation |
| addr_src | output | 2 | Source: 0 none, 1 core, 2 held, 3 incremented |
| pred_drop | output | 1 | Outstanding prediction discarded this cycle |

## Verification
The case most likely to go wrong is when checking a prediction and starting a new burst land in the same cycle. In `ST_CHECK` the core may present a mismatching read with `burst_more` set. The block must then drop the old prediction, issue the core address as a fresh transfer, and go straight to `ST_LEAD` for the new burst. A stall can also arrive while a check is pending, and it must freeze the comparison until `hready` returns. The bench forces these collisions with directed sequences, and random stimulus biases the core address toward the predicted one so that matches and misses both occur often. A reference model in the bench, built from the requirements, predicts every output in every cycle.

// File: rtl/bas_pkg.sv
package bas_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CORE = 2'd1,
        SRC_HELD = 2'd2,
        SRC_INCR = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_CHECK = 2'd2
    } st_e;

    localparam int PROT_W = 4;
    localparam int SIZE_W = 2;
endpackage

// File: rtl/bas_prot_enc.sv
module bas_prot_enc
    import bas_pkg::*;
(
    input  logic              is_write,
    input  logic              cacheable,
    input  logic              bufferable,
    input  logic              priv,
    input  logic              data,
    input  logic              ptw,
    output logic [PROT_W-1:0] prot
);
    // R8: cache bit only meaningful on reads, buffer bit only on writes
    always_comb begin
        prot[3] = ptw | (~is_write & cacheable);
        prot[2] = is_write & bufferable;
        prot[1] = priv;
        prot[0] = data;
    end
endmodule

// File: rtl/bas_incr.sv
module bas_incr
    import bas_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    output logic [ADDR_W-1:0] sum
);
    localparam int STEP_W = MAX_LOG2 + 1;

    logic [STEP_W-1:0] step;

    // R4: size code to byte count, saturating at the widest beat
    always_comb begin
        step = '0;
        for (int k = 0; k <= MAX_LOG2; k++) begin
            if (int'(size) == k || (k == MAX_LOG2 && int'(size) > MAX_LOG2)) begin
                step = STEP_W'(1) << k;
            end
        end
    end

    assign sum = base + {{(ADDR_W-STEP_W){1'b0}}, step};
endmodule

// File: rtl/bas_fsm.sv
module bas_fsm
    import bas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hready,
    input  logic core_valid,
    input  logic core_write,
    input  logic burst_more,
    input  logic merge_next,
    input  logic addr_match,
    output src_e src,
    output logic drop
);
    st_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else if (hready) begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        src    = SRC_NONE;
        drop   = 1'b0;
        if (!hready) begin
            src = SRC_HELD;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (core_valid) begin
                        src    = SRC_CORE;
                        st_nxt = (!core_write && burst_more) ? ST_LEAD : ST_IDLE;
                    end else if (merge_next) begin
                        src    = SRC_CORE;
                        st_nxt = ST_CHECK;
                    end
                end
                ST_LEAD: begin
                    src    = SRC_INCR;
                    st_nxt = ST_CHECK;
                end
                ST_CHECK: begin
                    if (core_valid && !core_write && addr_match) begin
                        if (burst_more) begin
                            src    = SRC_INCR;
                            st_nxt = ST_CHECK;
                        end else begin
                            st_nxt = ST_IDLE;
                        end
                    end else if (core_valid) begin
                        src    = SRC_CORE;
                        drop   = 1'b1;
                        st_nxt = (!core_write && burst_more) ? ST_LEAD : ST_IDLE;
                    end else begin
                        drop   = 1'b1;
                        st_nxt = ST_IDLE;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // R1
    idle_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && hready && core_valid) |-> (src == SRC_CORE && !drop));

    // R3
    lead_to_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LEAD && hready) |=> (st == ST_CHECK));

    // R6
    drop_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (src != SRC_INCR && st == ST_CHECK));

    // R7
    wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(st));
endmodule

// File: rtl/bridge_addr_sel.sv
module bridge_addr_sel
    import bas_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic              core_write,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [1:0]        core_size,
    input  logic              core_cacheable,
    input  logic              core_bufferable,
    input  logic              core_priv,
    input  logic              core_data,
    input  logic              core_ptw,
    input  logic              burst_more,
    input  logic              merge_next,
    input  logic              hready,
    output logic [ADDR_W-1:0] haddr,
    output logic [3:0]        hprot,
    output logic              addr_valid,
    output logic              addr_seq,
    output logic [1:0]        addr_src,
    output logic              pred_drop
);
    logic [ADDR_W-1:0] hold_addr_q, incr_addr;
    logic [PROT_W-1:0] hold_prot_q, live_prot;
    logic [SIZE_W-1:0] hold_size_q, size_now;
    logic              hold_valid_q, hold_seq_q;
    logic              addr_match, drop;
    src_e              src;

    bas_prot_enc u_prot (
        .is_write   (core_write),
        .cacheable  (core_cacheable),
        .bufferable (core_bufferable),
        .priv       (core_priv),
        .data       (core_data),
        .ptw        (core_ptw),
        .prot       (live_prot)
    );

    bas_incr #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2)) u_incr (
        .base (hold_addr_q),
        .size (hold_size_q),
        .sum  (incr_addr)
    );

    assign addr_match = (core_addr == hold_addr_q);

    bas_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready),
        .core_valid (core_valid),
        .core_write (core_write),
        .burst_more (burst_more),
        .merge_next (merge_next),
        .addr_match (addr_match),
        .src        (src),
        .drop       (drop)
    );

    always_comb begin
        haddr      = hold_addr_q;
        hprot      = hold_prot_q;
        size_now   = hold_size_q;
        addr_valid = 1'b0;
        addr_seq   = 1'b0;
        unique case (src)
            SRC_CORE: begin
                haddr      = core_addr;
                hprot      = live_prot;
                size_now   = core_size;
                addr_valid = 1'b1;
            end
            SRC_INCR: begin
                haddr      = incr_addr;
                addr_valid = 1'b1;
                addr_seq   = 1'b1;
            end
            SRC_HELD: begin
                addr_valid = hold_valid_q;
                addr_seq   = hold_seq_q;
            end
            default: ;
        endcase
    end

    assign addr_src  = src;
    assign pred_drop = drop;

    // capture the bus view on every accepted cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr_q  <= '0;
            hold_prot_q  <= '0;
            hold_size_q  <= '0;
            hold_valid_q <= 1'b0;
            hold_seq_q   <= 1'b0;
        end else if (hready) begin
            hold_addr_q  <= haddr;
            hold_prot_q  <= hprot;
            hold_size_q  <= size_now;
            hold_valid_q <= addr_valid;
            hold_seq_q   <= addr_seq;
        end
    end

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && !$past(hready)) |-> ($stable(haddr) && $stable(hprot) && $stable(addr_valid)));

    // R3
    seq_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_seq |-> addr_valid);

    // R8
    ptw_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && addr_src == SRC_CORE && core_ptw) |-> hprot[3]);

    // R9
    incr_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && addr_src == SRC_INCR && $past(hready)) |-> (hprot == $past(hprot)));
endmodule

// File: tb/bridge_addr_sel_test.sv
module bridge_addr_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cv = 0, cw = 0, cc = 0, cb = 0, cp = 0, cd = 0, ct = 0, more = 0, merge = 0, hr = 1;
    logic [AW-1:0] ca = '0;
    logic [1:0] cs = 2'd2;
    logic [AW-1:0] haddr;
    logic [3:0] hprot;
    logic addr_valid, addr_seq, pred_drop;
    logic [1:0] addr_src;

    int checks = 0;
    int failures = 0;

    bridge_addr_sel #(.ADDR_W(AW), .MAX_LOG2(2)) uut (
        .clk(clk), .rst_n(rst_n), .core_valid(cv), .core_write(cw), .core_addr(ca),
        .core_size(cs), .core_cacheable(cc), .core_bufferable(cb), .core_priv(cp),
        .core_data(cd), .core_ptw(ct), .burst_more(more), .merge_next(merge), .hready(hr),
        .haddr(haddr), .hprot(hprot), .addr_valid(addr_valid), .addr_seq(addr_seq),
        .addr_src(addr_src), .pred_drop(pred_drop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int m_st = 0;
    logic [AW-1:0] m_addr = '0;
    logic [3:0] m_prot = '0;
    logic [1:0] m_size = '0;
    logic m_valid = 0, m_seq = 0;

    // expected values
    logic [AW-1:0] e_addr;
    logic [3:0] e_prot;
    logic [1:0] e_size, e_src;
    logic e_valid, e_seq, e_drop;
    int e_nst;
    string tag, ptag;

    function automatic logic [3:0] prot_of(logic w, logic c, logic b, logic p, logic d, logic t);
        return {t | (~w & c), w & b, p, d};
    endfunction

    function automatic logic [AW-1:0] beat_bytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    task automatic take_core();
        e_src = 2'd1; e_valid = 1; e_seq = 0;
        e_addr = ca; e_prot = prot_of(cw, cc, cb, cp, cd, ct); e_size = cs;
        ptag = "R8";
    endtask

    task automatic compute_exp();
        e_src = 0; e_valid = 0; e_seq = 0; e_drop = 0;
        e_addr = m_addr; e_prot = m_prot; e_size = m_size; e_nst = m_st;
        tag = "R1"; ptag = "R7";
        if (!hr) begin
            e_src = 2'd2; e_valid = m_valid; e_seq = m_seq; tag = "R7";
        end else begin
            case (m_st)
                0: begin
                    if (cv) begin
                        take_core(); tag = "R1";
                        e_nst = (!cw && more) ? 1 : 0;
                    end else if (merge) begin
                        take_core(); tag = "R2"; e_nst = 2;
                    end else begin
                        tag = "R10";
                    end
                end
                1: begin
                    e_src = 2'd3; e_valid = 1; e_seq = 1;
                    e_addr = m_addr + beat_bytes(m_size);
                    tag = "R3 R4"; ptag = "R9"; e_nst = 2;
                end
                default: begin
                    if (cv && !cw && ca == m_addr) begin
                        tag = "R5";
                        if (more) begin
                            e_src = 2'd3; e_valid = 1; e_seq = 1;
                            e_addr = m_addr + beat_bytes(m_size);
                            ptag = "R9"; e_nst = 2;
                        end else begin
                            e_nst = 0;
                        end
                    end else if (cv) begin
                        take_core(); tag = "R6"; e_drop = 1;
                        e_nst = (!cw && more) ? 1 : 0;
                    end else begin
                        tag = "R6"; e_drop = 1; e_nst = 0;
                    end
                end
            endcase
        end
    endtask

    task automatic check_now();
        compute_exp();
        checks++;
        if (haddr !== e_addr || addr_valid !== e_valid || addr_src !== e_src ||
            addr_seq !== e_seq || pred_drop !== e_drop) begin
            failures++;
            $display("FAIL %s: addr=%h v=%0b src=%0d seq=%0b drop=%0b expected addr=%h v=%0b src=%0d seq=%0b drop=%0b",
                     tag, haddr, addr_valid, addr_src, addr_seq, pred_drop,
                     e_addr, e_valid, e_src, e_seq, e_drop);
        end
        checks++;
        if (hprot !== e_prot) begin
            failures++;
            $display("FAIL %s: hprot=%b expected %b", ptag, hprot, e_prot);
        end
    endtask

    task automatic update_model();
        if (hr) begin
            m_addr = e_addr; m_prot = e_prot; m_size = e_size;
            m_valid = e_valid; m_seq = e_seq; m_st = e_nst;
        end
    endtask

    // one cycle: drive after negedge, check mid-cycle, advance model at posedge
    task automatic step(logic v, logic w, logic [AW-1:0] a, logic [1:0] s, logic c,
                        logic b, logic p, logic d, logic t, logic mo, logic mg, logic r);
        @(negedge clk);
        cv = v; cw = w; ca = a; cs = s; cc = c; cb = b; cp = p; cd = d; ct = t;
        more = mo; merge = mg; hr = r;
        #1;
        check_now();
        @(posedge clk);
        update_model();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        step(0, 0, 32'h55, 2'd2, 0, 0, 0, 0, 0, 0, 0, 1);
        // R7: wait straight after reset holds zeros
        step(1, 0, 32'h99, 2'd2, 0, 0, 0, 1, 0, 0, 0, 0);

        // R3 R5: word read burst; core inputs in lead cycle are junk (ignored)
        step(1, 0, 32'h1000, 2'd2, 0, 0, 1, 1, 0, 1, 0, 1);
        step(1, 1, 32'hDEAD, 2'd0, 1, 1, 0, 0, 1, 0, 1, 1);
        step(1, 0, 32'h1004, 2'd2, 0, 0, 1, 1, 0, 1, 0, 1);
        step(1, 0, 32'h1008, 2'd2, 0, 0, 1, 1, 0, 1, 0, 0);  // R7 wait in check
        step(1, 0, 32'h1008, 2'd2, 0, 0, 1, 1, 0, 1, 0, 1);
        step(1, 0, 32'h100C, 2'd2, 0, 0, 1, 1, 0, 0, 0, 1);  // R5 end

        // R4: halfword and byte bursts
        step(1, 0, 32'h2001, 2'd1, 0, 0, 0, 1, 0, 1, 0, 1);
        step(0, 0, 32'h0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 32'h2003, 2'd1, 0, 0, 0, 1, 0, 0, 0, 1);
        step(1, 0, 32'h3000, 2'd0, 0, 0, 0, 1, 0, 1, 0, 1);
        step(0, 0, 32'h0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 32'h3001, 2'd0, 0, 0, 0, 1, 0, 0, 0, 1);
        // R4: wrap at top of address space
        step(1, 0, 32'hFFFF_FFFC, 2'd3, 0, 0, 0, 1, 0, 1, 0, 1);
        step(0, 0, 32'h0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R6: mismatch with new burst hint, collides with check
        step(1, 0, 32'h4000, 2'd2, 0, 0, 0, 1, 0, 1, 0, 1);
        step(0, 0, 32'h0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R6: core absent in check
        step(0, 0, 32'h0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R2: merged idle-then-sequential, then confirmed
        step(0, 0, 32'h5000, 2'd2, 0, 0, 1, 1, 0, 0, 1, 1);
        step(1, 0, 32'h5000, 2'd2, 0, 0, 1, 1, 0, 0, 0, 1);
        // R6: write during check
        step(0, 0, 32'h6000, 2'd2, 0, 0, 1, 1, 0, 0, 1, 1);
        step(1, 1, 32'h6000, 2'd2, 1, 1, 1, 1, 0, 0, 0, 1);
        // R8: page-table walk read, cacheable write, bufferable read
        step(1, 0, 32'h7000, 2'd2, 0, 1, 1, 1, 1, 0, 0, 1);
        step(1, 1, 32'h7004, 2'd2, 1, 1, 0, 0, 0, 0, 0, 1);
        step(1, 0, 32'h7008, 2'd2, 1, 1, 1, 0, 0, 0, 0, 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic v, w, mo, mg, r, t;
            logic [AW-1:0] a;
            v  = ($urandom % 10) < 7;
            w  = ($urandom % 4) == 0;
            mo = ($urandom % 2) == 0;
            mg = ($urandom % 7) == 0;
            r  = ($urandom % 8) != 0;
            t  = ($urandom % 10) == 0;
            a  = $urandom;
            if (m_st == 2 && ($urandom % 4) != 0) begin
                a = m_addr;
                w = 1'b0;
            end
            step(v, w, a, 2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), t, mo, mg, r);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule